// File: doc/BRIEF.md
# PCI Target Cycle Controller

This block is the target-side cycle sequencer for a 32-bit PCI agent. It watches the shared bus signals: the framing strobe, the initiator-ready strobe, the command/byte-enable lines and the multiplexed address/data lines. On the clock where the framing strobe first goes low, it captures the address and the bus command. It then decides whether the cycle belongs to this device. The device claims only memory reads and memory writes whose address falls inside one naturally aligned, power-of-two window. The window's base and size are parameters.

For a claimed cycle, the block drives the device-select, target-ready and stop strobes, and it controls the enable of the data drivers. Read cycles get one turnaround clock before the block drives the data lines. Write cycles go straight into their data phase.

On the local side, a one-word handshake moves the data. The block presents the current word address and the direction. The local logic answers with a ready input, and holding ready low inserts wait states. A transfer pulse marks each clock in which a word actually moves. Bursts advance the word address by four. If a burst would run past the end of the window, the block signals a disconnect with the stop strobe.

Top module: `pci_tgt_ctrl`

## Requirements
- R1: A cycle starts only on a clock edge where `frame_n` is sampled low while it was high at the edge before, in the idle state. Address bits [31:2] and the command are captured at that edge. A low `frame_n` that is held over from an earlier cycle starts nothing.
- R2: The device claims a cycle, and drives `devsel_n` low from the clock after the address phase, only when two conditions hold. The command must be 4'b0110 (memory read) or 4'b0111 (memory write). The address must satisfy addr[31:SIZE_LOG2] == BASE[31:SIZE_LOG2].
- R3: For a claimed read, the first clock after the address phase is a turnaround. In it, `devsel_n`=0, `trdy_n`=1 and `ad_oe`=0. In the data clocks that follow, `ad_oe`=1 and `ad_out` equals `loc_rdata`.
- R4: For a claimed write, the data phase begins in the first clock after the address phase. `ad_oe` stays 0, `loc_write`=1, `loc_wdata` mirrors `ad_in`, and `loc_be` is the inverse of `cbe_n`.
- R5: During a data phase, `trdy_n` is low exactly when `loc_ready` is high. Each clock with `loc_ready` low adds one wait clock, with no transfer.
- R6: A word moves in a data-phase clock in which `trdy_n` and `irdy_n` are both low, and `loc_xfer`=1 in that clock. After each transfer, `loc_addr` advances by 4. The first beat uses the captured address.
- R7: A transfer with `frame_n` high is the final one. In the next clock, `ctl_oe`=1 with `devsel_n`, `trdy_n` and `stop_n` all high and `ad_oe`=0. In the clock after that, `ctl_oe`=0 if the bus is idle (`frame_n` and `irdy_n` both high).
- R8: When `loc_addr` is the last word of the window (bits [SIZE_LOG2-1:2] all ones) and `frame_n` is low during a data phase, `stop_n` is low. After the transfer, `stop_n` and `devsel_n` stay low, with `trdy_n` high, until `frame_n` is sampled high. Release then follows as in R7.
- R9: An unclaimed cycle drives nothing: `ctl_oe`, `ad_oe` and `loc_xfer` stay 0 until the bus returns to idle.
- R10: While reset is asserted and right after it, `ctl_oe`=0, `ad_oe`=0, `loc_xfer`=0 and all bus strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Cycle framing strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command (address phase) / byte enables (data phase), active low |
| ad_in | input | 32 | Address/data lines as seen on the bus |
| ad_out | output | 32 | Read data to drive onto the bus |
| ad_oe | output | 1 | Enable for the address/data drivers |
| ctl_oe | output | 1 | Enable for the target control strobe drivers |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop / disconnect request, active low |
| loc_addr | output | 32 | Word address of the current data phase |
| loc_write | output | 1 | Current cycle is a write |
| loc_xfer | output | 1 | A word moves in this clock |
| loc_be | output | 4 | Byte enables, active high |
| loc_wdata | output | 32 | Write data toward local logic |
| loc_rdata | input | 32 | Read data from local logic |
| loc_ready | input | 1 | Local logic can complete the current data phase |

## Verification
The hardest case to reach is a disconnect. It happens only when a burst is still framed as it reaches the top word of the window. The stimulus therefore starts bursts a few words below the window's end, asks for more beats than remain, and adds wait states. This shows that the stop strobe is held through the idle data clocks and through the extra clock before the initiator drops the framing strobe. It also runs a single beat on the last word, with the framing strobe already high, to confirm that no stop is raised. A further case keeps the framing strobe low after an unclaimed cycle while the address lines move into the window, and checks that no second claim appears.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
    localparam int AD_W = 32;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_DATA,
        ST_DISC,
        ST_REL,
        ST_BUSY
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e        state;
        logic              frame_prev;
        logic              is_write;
        logic [AD_W-1:0]   addr;
    } tgt_regs_t;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter logic [AD_W-1:0] BASE      = 32'h4000_0000,
    parameter int              SIZE_LOG2 = 6
) (
    input  logic [AD_W-1:SIZE_LOG2] win_bits,
    input  logic [3:0]              cbe_n,
    output logic                    hit,
    output logic                    is_write
);
    logic cmd_ok;
    logic in_win;

    always_comb begin
        cmd_ok   = (cbe_n == CMD_MEM_RD) || (cbe_n == CMD_MEM_WR);
        in_win   = (win_bits == BASE[AD_W-1:SIZE_LOG2]);
        hit      = cmd_ok && in_win;
        is_write = (cbe_n == CMD_MEM_WR);
    end
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
    import pci_tgt_pkg::*;
#(
    parameter int SIZE_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [AD_W-1:2]  ad_word,
    input  logic             hit,
    input  logic             dec_write,
    input  logic             loc_ready,
    output logic             ad_oe,
    output logic             ctl_oe,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n,
    output logic [AD_W-1:0]  loc_addr,
    output logic             loc_write,
    output logic             loc_xfer
);
    localparam logic [AD_W-1:0] STEP = AD_W'(4);

    tgt_regs_t r_q, r_d;
    logic      at_last;
    logic      xfer;
    logic      bus_idle;

    always_comb begin
        at_last  = &r_q.addr[SIZE_LOG2-1:2];
        bus_idle = frame_n && irdy_n;
        xfer     = (r_q.state == ST_DATA) && loc_ready && !irdy_n;

        r_d            = r_q;
        r_d.frame_prev = frame_n;

        case (r_q.state)
            ST_IDLE: begin
                if (r_q.frame_prev && !frame_n) begin
                    r_d.addr     = {ad_word, 2'b00};
                    r_d.is_write = dec_write;
                    if (!hit)          r_d.state = ST_BUSY;
                    else if (dec_write) r_d.state = ST_DATA;
                    else               r_d.state = ST_TURN;
                end
            end
            ST_TURN: r_d.state = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    r_d.addr = r_q.addr + STEP;
                    if (frame_n)      r_d.state = ST_REL;
                    else if (at_last) r_d.state = ST_DISC;
                end
            end
            ST_DISC: if (frame_n) r_d.state = ST_REL;
            ST_REL:  r_d.state = bus_idle ? ST_IDLE : ST_BUSY;
            ST_BUSY: if (bus_idle) r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state      <= ST_IDLE;
            r_q.frame_prev <= 1'b1;
            r_q.is_write   <= 1'b0;
            r_q.addr       <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ctl_oe    = (r_q.state == ST_TURN) || (r_q.state == ST_DATA) ||
                    (r_q.state == ST_DISC) || (r_q.state == ST_REL);
        devsel_n  = !((r_q.state == ST_TURN) || (r_q.state == ST_DATA) ||
                      (r_q.state == ST_DISC));
        trdy_n    = !((r_q.state == ST_DATA) && loc_ready);
        stop_n    = !((r_q.state == ST_DISC) ||
                      ((r_q.state == ST_DATA) && at_last && !frame_n));
        ad_oe     = (r_q.state == ST_DATA) && !r_q.is_write;
        loc_addr  = r_q.addr;
        loc_write = r_q.is_write;
        loc_xfer  = xfer;
    end

    AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> $past(!devsel_n && trdy_n)); // R3

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!loc_write && !devsel_n)); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_xfer && !frame_n && stop_n) |=> (loc_addr == $past(loc_addr) + STEP)); // R6

    AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_xfer && frame_n) |=> (ctl_oe && devsel_n && trdy_n && stop_n && !ad_oe)); // R7

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DISC && !frame_n) |=> (!stop_n && !devsel_n)); // R8

    AST_XFER_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        loc_xfer |-> (!devsel_n && !trdy_n && !irdy_n)); // R6
endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] BASE      = 32'h4000_0000,
    parameter int          SIZE_LOG2 = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        ctl_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic [31:0] loc_addr,
    output logic        loc_write,
    output logic        loc_xfer,
    output logic [3:0]  loc_be,
    output logic [31:0] loc_wdata,
    input  logic [31:0] loc_rdata,
    input  logic        loc_ready
);
    logic hit;
    logic dec_write;

    pci_tgt_decode #(
        .BASE      (BASE),
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_decode (
        .win_bits (ad_in[AD_W-1:SIZE_LOG2]),
        .cbe_n    (cbe_n),
        .hit      (hit),
        .is_write (dec_write)
    );

    pci_tgt_fsm #(
        .SIZE_LOG2 (SIZE_LOG2)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .ad_word   (ad_in[AD_W-1:2]),
        .hit       (hit),
        .dec_write (dec_write),
        .loc_ready (loc_ready),
        .ad_oe     (ad_oe),
        .ctl_oe    (ctl_oe),
        .devsel_n  (devsel_n),
        .trdy_n    (trdy_n),
        .stop_n    (stop_n),
        .loc_addr  (loc_addr),
        .loc_write (loc_write),
        .loc_xfer  (loc_xfer)
    );

    always_comb begin
        ad_out    = loc_rdata;
        loc_wdata = ad_in;
        loc_be    = ~cbe_n;
    end
endmodule

// File: tb/pci_tgt_ctrl_bench.sv
module pci_tgt_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // fields: cmd[49:46] addr[45:14] beats[13:10] waits[9:6] hit[5] done[4:1] stop[0]
    localparam logic [49:0] VECS [NVEC] = '{
        {4'h7, 32'h4000_0000, 4'd3, 4'd0, 1'b1, 4'd3, 1'b0},
        {4'h6, 32'h4000_0010, 4'd2, 4'd2, 1'b1, 4'd2, 1'b0},
        {4'h6, 32'h4000_0038, 4'd4, 4'd0, 1'b1, 4'd2, 1'b1},
        {4'h7, 32'h4000_003C, 4'd1, 4'd1, 1'b1, 4'd1, 1'b0},
        {4'h6, 32'h4000_0040, 4'd2, 4'd0, 1'b0, 4'd0, 1'b0},
        {4'h2, 32'h4000_0000, 4'd2, 4'd0, 1'b0, 4'd0, 1'b0},
        {4'h7, 32'h4000_0034, 4'd4, 4'd1, 1'b1, 4'd3, 1'b1},
        {4'h6, 32'h3FFF_FFFC, 4'd1, 4'd0, 1'b0, 4'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] loc_rdata = '0;
    logic        loc_ready = 1'b0;
    logic [31:0] ad_out, loc_addr, loc_wdata;
    logic [3:0]  loc_be;
    logic        ad_oe, ctl_oe, devsel_n, trdy_n, stop_n, loc_write, loc_xfer;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_tgt_ctrl u_pci_tgt_ctrl (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .ctl_oe(ctl_oe), .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .loc_addr(loc_addr), .loc_write(loc_write), .loc_xfer(loc_xfer),
        .loc_be(loc_be), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .loc_ready(loc_ready)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_vec(input logic [49:0] v);
        logic [3:0]  cmd;
        logic [31:0] addr;
        int          beats, waits, done;
        logic        ehit, estop, stopped, rd;
        cmd   = v[49:46];
        addr  = v[45:14];
        beats = int'(v[13:10]);
        waits = int'(v[9:6]);
        ehit  = v[5];
        done  = 0;
        estop = v[0];
        stopped = 1'b0;
        rd = (cmd == 4'h6);

        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; loc_ready = 1'b0;
        @(negedge clk);
        chk(devsel_n == !ehit, "R2 claim decision", {31'b0, devsel_n}, {31'b0, !ehit});
        if (!ehit) begin
            for (int i = 0; i < 2; i++) begin
                chk(!ctl_oe && !ad_oe && !loc_xfer, "R9 miss stays quiet",
                    {29'b0, ctl_oe, ad_oe, loc_xfer}, 32'h0);
                @(negedge clk);
            end
            frame_n = 1'b1; irdy_n = 1'b0;
            @(negedge clk);
            irdy_n = 1'b1;
            @(negedge clk);
            chk(!ctl_oe && devsel_n, "R9 miss after abort",
                {30'b0, ctl_oe, devsel_n}, 32'h1);
            return;
        end
        if (rd) begin
            chk(trdy_n && !ad_oe && ctl_oe, "R3 turnaround clock",
                {29'b0, trdy_n, ad_oe, ctl_oe}, 32'h5);
            @(negedge clk);
        end
        for (int b = 0; b < beats; b++) begin
            irdy_n = 1'b0;
            frame_n = (b == beats - 1);
            ad_in = 32'hA500_0000 + b;
            cbe_n = 4'b0101;
            loc_rdata = 32'hC0DE_0000 + b;
            loc_ready = 1'b0;
            for (int w = 0; w < waits; w++) begin
                #1;
                chk(trdy_n && !loc_xfer, "R5 wait clock", {30'b0, trdy_n, loc_xfer}, 32'h2);
                @(negedge clk);
            end
            loc_ready = 1'b1;
            #1;
            chk(!trdy_n && loc_xfer, "R6 transfer", {30'b0, trdy_n, loc_xfer}, 32'h1);
            chk(loc_addr == addr + 32'(4*b), "R6 word address", loc_addr, addr + 32'(4*b));
            if (rd) begin
                chk(ad_oe && ad_out == loc_rdata, "R3 read data driven", ad_out, loc_rdata);
            end else begin
                chk(!ad_oe && loc_write && loc_wdata == ad_in && loc_be == 4'b1010,
                    "R4 write data path", loc_wdata, ad_in);
            end
            done++;
            if (!stop_n) begin
                stopped = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (stopped) begin
            @(negedge clk);
            loc_ready = 1'b0;
            #1;
            chk(!stop_n && !devsel_n && trdy_n, "R8 stop held after disconnect",
                {29'b0, stop_n, devsel_n, trdy_n}, 32'h1);
            @(negedge clk);
            #1;
            chk(!stop_n && !devsel_n, "R8 stop held while framed",
                {30'b0, stop_n, devsel_n}, 32'h0);
            frame_n = 1'b1; irdy_n = 1'b1;
            @(negedge clk);
        end else begin
            irdy_n = 1'b1;
            loc_ready = 1'b0;
        end
        #1;
        chk(ctl_oe && devsel_n && trdy_n && stop_n && !ad_oe, "R7 release clock",
            {27'b0, ctl_oe, devsel_n, trdy_n, stop_n, ad_oe}, 32'h1E);
        @(negedge clk);
        chk(!ctl_oe, "R7 drivers off", {31'b0, ctl_oe}, 32'h0);
        chk(done == int'(v[4:1]), "R6 beats moved", 32'(done), 32'(v[4:1]));
        chk(stopped == estop, "R8 disconnect seen", {31'b0, stopped}, {31'b0, estop});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk(!ctl_oe && !ad_oe && !loc_xfer && devsel_n && trdy_n && stop_n,
            "R10 reset state", {26'b0, ctl_oe, ad_oe, loc_xfer, devsel_n, trdy_n, stop_n}, 32'h7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ctl_oe && devsel_n, "R10 after reset", {30'b0, ctl_oe, devsel_n}, 32'h1);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R1: framing strobe held low past an unclaimed cycle must not start a new claim
        @(negedge clk);
        frame_n = 1'b0; ad_in = 32'h5000_0000; cbe_n = 4'h6;
        @(negedge clk);
        chk(devsel_n, "R2 out-of-window read", {31'b0, devsel_n}, 32'h1);
        ad_in = 32'h4000_0008; cbe_n = 4'h7;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(devsel_n && !ctl_oe, "R1 no claim without falling frame",
                {30'b0, devsel_n, ctl_oe}, 32'h2);
        end
        frame_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        // R1: a fresh falling edge with the same lines claims, with captured address
        frame_n = 1'b0;
        @(negedge clk);
        ad_in = 32'h0000_0000; cbe_n = 4'h0;
        frame_n = 1'b1; irdy_n = 1'b0; loc_ready = 1'b1;
        #1;
        chk(!devsel_n && loc_addr == 32'h4000_0008 && loc_write, "R1 captured address",
            loc_addr, 32'h4000_0008);
        @(negedge clk);
        irdy_n = 1'b1; loc_ready = 1'b0;
        @(negedge clk);
        chk(!ctl_oe, "R7 drivers off after single write", {31'b0, ctl_oe}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule